// File: doc/BRIEF.md
# Stereo serial-to-biphase-mark audio transmitter

The block takes a stereo audio stream on a three-wire serial link (bit clock, word select and data) and turns it into a single biphase-mark coded line. All three serial inputs are sampled by the system clock. A bit is taken on every rising edge of the bit clock. The word alignment is picked by a two-bit mode input: the standard two-channel inter-IC format, left-justified or right-justified. A second two-bit input picks the word length: 16, 18, 20 or 24 bits.

Each completed left/right pair is packed into two 32-slot subframes. Each subframe starts with a 4-slot sync preamble, then carries 24 audio slots, a validity slot, a user slot, a channel-status slot and a parity slot. The output advances one half-slot per pulse of an encode tick input, so the tick rate must be 128 times the frame rate. The channel-status bit of each frame comes from a wide static input indexed by the frame number within the block. Validity and user bits are always zero.

Top module: `spdif_bmc_tx`

## Requirements
- R1: After reset the line output is low and the next encode tick starts a left subframe of frame 0 of a block.
- R2: In mode 0 (inter-IC), word select low marks the left word, and the MSB is the second bit sampled after a word-select change.
- R3: In mode 1 (left-justified), word select high marks the left word, and the MSB is the first bit sampled after a word-select change.
- R4: In mode 2 (right-justified), word select high marks the left word, and the LSB is the last bit sampled before a word-select change.
- R5: The width code selects the word length: 0 is 16 bits, 1 is 18, 2 is 20 and 3 is 24. The word is placed MSB-aligned in a 24-bit field, and the unused low audio slots are zero.
- R6: Subframe slots 4 to 27 carry the 24-bit field LSB first. Slot 28 (validity) and slot 29 (user) are zero.
- R7: Slot 31 is set so that slots 4 to 31 hold an even number of ones.
- R8: In slots 4 to 31 the line toggles at the start of every slot, and toggles again in mid-slot exactly when the slot bit is 1.
- R9: Slots 0 to 3 carry an 8-half-slot pattern taken from 11101000, 11100010 or 11100100 (first half-slot leftmost). The pattern is inverted when the line was high before the subframe.
- R10: The first pattern marks the left subframe of frame 0 of each block of BLOCK_LEN (192) frames. The second marks every other left subframe. The third marks every right subframe.
- R11: Slot 30 of both subframes of frame f carries bit f of the channel-status input.
- R12: The line changes only on the clock edge where the encode tick is high, and it advances exactly one half-slot per tick.
- R13: The two subframes of a frame carry a left word and a right word received in the same word-select period. Consecutive frames carry consecutive received pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_i | input | 2 | Serial alignment mode (0 inter-IC, 1 left-justified, 2 right-justified) |
| wsel_i | input | 2 | Word length code |
| sclk_i | input | 1 | Serial bit clock, sampled |
| lrck_i | input | 1 | Serial word select, sampled |
| sdata_i | input | 1 | Serial data, sampled |
| enc_tick_i | input | 1 | Half-slot advance pulse |
| chstat_i | input | BLOCK_LEN | Channel-status bits, one per frame of a block |
| spdif_o | output | 1 | Biphase-mark coded line |

## Verification
A wrong half-slot or subframe count shows within one subframe: a slot boundary loses its transition, or a preamble appears at the wrong place. A word-alignment or width fault corrupts the audio field of the first full frame: the fixed upper pattern of each word shifts, or nonzero bits appear in the padding slots. A wrong frame counter shows first as a channel-status slot mismatch, and at the latest as a misplaced block-start preamble 192 frames after reset. The bench decodes the line half-slot by half-slot and sweeps all twelve mode and width combinations.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;

   typedef enum logic [1:0] {
      FMT_IIS   = 2'd0,
      FMT_LEFT  = 2'd1,
      FMT_RIGHT = 2'd2
   } ser_fmt_e;

   // 8 half-slot sync shapes, first half-slot in bit 7, for a line that was low
   localparam logic [7:0] SYNC_BLOCK = 8'b1110_1000;
   localparam logic [7:0] SYNC_LEFT  = 8'b1110_0010;
   localparam logic [7:0] SYNC_RIGHT = 8'b1110_0100;

   localparam int unsigned SLOT_HALVES = 64;
   localparam int unsigned AUD_BITS    = 24;

   function automatic int unsigned word_len(input logic [1:0] code);
      case (code)
         2'd0:    return 16;
         2'd1:    return 18;
         2'd2:    return 20;
         default: return 24;
      endcase
   endfunction

endpackage

// File: rtl/ser_in_deser.sv
module ser_in_deser
   import spdif_tx_pkg::*;
#(
   parameter int unsigned MAX_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       fmt,
   input  logic [1:0]       wsel,
   input  logic             sclk,
   input  logic             lrck,
   input  logic             sdat,
   output logic [MAX_W-1:0] pair_l,
   output logic [MAX_W-1:0] pair_r,
   output logic             pair_vld
);

   localparam int unsigned IDX_W   = 6;
   localparam logic [IDX_W-1:0] IDX_MAX = '1;

   if (MAX_W != AUD_BITS) begin : g_bad_width
      $error("ser_in_deser: MAX_W must equal the audio field width");
   end

   logic             sclk_q, lr_q, rise, trans, left_lvl;
   logic [MAX_W-1:0] shreg, acc, acc_n, left_hold, done_word;
   logic [IDX_W-1:0] idx, k;
   logic [MAX_W-1:0] rj_just [4];
   int               wlen;

   // one right-justified candidate per selectable width
   for (genvar g = 0; g < 4; g++) begin : g_rj
      localparam int unsigned WG = word_len(2'(g));
      assign rj_just[g] = MAX_W'(shreg[WG-1:0]) << (MAX_W - WG);
   end

   assign rise     = sclk & ~sclk_q;
   assign trans    = rise && (lrck != lr_q);
   assign k        = trans ? '0 : idx;
   assign wlen     = int'(word_len(wsel));
   assign left_lvl = (fmt != FMT_IIS);
   assign done_word = (fmt == FMT_RIGHT) ? rj_just[wsel] : acc;

   always_comb begin
      acc_n = trans ? '0 : acc;
      if (fmt == FMT_IIS) begin
         if (k != '0 && int'(k) <= wlen) acc_n[MAX_W - int'(k)] = sdat;
      end else if (fmt == FMT_LEFT) begin
         if (int'(k) < wlen) acc_n[MAX_W - 1 - int'(k)] = sdat;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_q    <= 1'b0;
         lr_q      <= 1'b0;
         shreg     <= '0;
         acc       <= '0;
         idx       <= IDX_MAX;
         left_hold <= '0;
         pair_l    <= '0;
         pair_r    <= '0;
         pair_vld  <= 1'b0;
      end else begin
         sclk_q   <= sclk;
         pair_vld <= 1'b0;
         if (rise) begin
            lr_q  <= lrck;
            shreg <= {shreg[MAX_W-2:0], sdat};
            acc   <= acc_n;
            idx   <= trans ? IDX_W'(1) : ((idx == IDX_MAX) ? idx : idx + 1'b1);
            if (trans) begin
               if (lr_q == left_lvl) begin
                  left_hold <= done_word;
               end else begin
                  pair_l   <= left_hold;
                  pair_r   <= done_word;
                  pair_vld <= 1'b1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/bmc_framer.sv
module bmc_framer
   import spdif_tx_pkg::*;
#(
   parameter int unsigned BLOCK_LEN = 192,
   parameter int unsigned FW        = $clog2(BLOCK_LEN)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic [BLOCK_LEN-1:0] cs_bits,
   input  logic [AUD_BITS-1:0]  smp_l,
   input  logic [AUD_BITS-1:0]  smp_r,
   output logic                 line_o,
   output logic [5:0]           half_o,
   output logic [FW-1:0]        fidx_o
);

   localparam logic [FW-1:0] LAST_FRAME = FW'(BLOCK_LEN - 1);

   if (BLOCK_LEN < 2) begin : g_bad_block
      $error("bmc_framer: BLOCK_LEN must be at least 2");
   end

   logic [5:0]          half_q;
   logic [4:0]          slot;
   logic                right_q, line_q, pol_q, ppol, dbit, cs_bit, par, line_n;
   logic [FW-1:0]       fidx_q;
   logic [AUD_BITS-1:0] l_q, r_q, aud;
   logic [7:0]          pat;

   assign slot   = half_q[5:1];
   assign aud    = right_q ? r_q : l_q;
   assign cs_bit = cs_bits[fidx_q];
   assign par    = ^aud ^ cs_bit;
   assign pat    = right_q ? SYNC_RIGHT : ((fidx_q == '0) ? SYNC_BLOCK : SYNC_LEFT);
   assign ppol   = (half_q == '0) ? line_q : pol_q;

   always_comb begin
      case (slot)
         5'd28, 5'd29: dbit = 1'b0;
         5'd30:        dbit = cs_bit;
         5'd31:        dbit = par;
         default:      dbit = aud[slot - 5'd4];
      endcase
      if (half_q < 6'd8)     line_n = pat[3'd7 - half_q[2:0]] ^ ppol;
      else if (!half_q[0])   line_n = ~line_q;
      else                   line_n = line_q ^ dbit;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         half_q  <= '0;
         right_q <= 1'b0;
         fidx_q  <= '0;
         line_q  <= 1'b0;
         pol_q   <= 1'b0;
         l_q     <= '0;
         r_q     <= '0;
      end else if (tick) begin
         line_q <= line_n;
         half_q <= half_q + 1'b1;
         if (half_q == '0) begin
            pol_q <= line_q;
            if (!right_q) begin
               l_q <= smp_l;
               r_q <= smp_r;
            end
         end
         if (half_q == 6'd63) begin
            right_q <= ~right_q;
            if (right_q) fidx_q <= (fidx_q == LAST_FRAME) ? '0 : fidx_q + 1'b1;
         end
      end
   end

   assign line_o = line_q;
   assign half_o = half_q;
   assign fidx_o = fidx_q;

endmodule

// File: rtl/spdif_bmc_tx.sv
module spdif_bmc_tx
   import spdif_tx_pkg::*;
#(
   parameter int unsigned BLOCK_LEN = 192
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           fmt_i,
   input  logic [1:0]           wsel_i,
   input  logic                 sclk_i,
   input  logic                 lrck_i,
   input  logic                 sdata_i,
   input  logic                 enc_tick_i,
   input  logic [BLOCK_LEN-1:0] chstat_i,
   output logic                 spdif_o
);

   localparam int unsigned FW = $clog2(BLOCK_LEN);

   logic [AUD_BITS-1:0] pl_w, pr_w;
   logic                pair_vld_w;
   logic [5:0]          half_w;
   logic [FW-1:0]       fidx_w;

   ser_in_deser #(.MAX_W(AUD_BITS)) u_deser (
      .clk      (clk),
      .rst_n    (rst_n),
      .fmt      (fmt_i),
      .wsel     (wsel_i),
      .sclk     (sclk_i),
      .lrck     (lrck_i),
      .sdat     (sdata_i),
      .pair_l   (pl_w),
      .pair_r   (pr_w),
      .pair_vld (pair_vld_w)
   );

   bmc_framer #(.BLOCK_LEN(BLOCK_LEN), .FW(FW)) u_framer (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (enc_tick_i),
      .cs_bits (chstat_i),
      .smp_l   (pl_w),
      .smp_r   (pr_w),
      .line_o  (spdif_o),
      .half_o  (half_w),
      .fidx_o  (fidx_w)
   );

endmodule

// File: rtl/spdif_bmc_tx_chk.sv
module spdif_bmc_tx_chk #(
   parameter int unsigned BLOCK_LEN = 192,
   parameter int unsigned FW        = $clog2(BLOCK_LEN)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tick,
   input logic          line,
   input logic [5:0]    half,
   input logic [FW-1:0] fidx,
   input logic          pvld
);

   p_slot_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && half >= 6'd8 && !half[0]) |=> (line != $past(line)));

   p_hold_line_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(line) && $stable(half)));

   p_wrap_half_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && half == 6'd63) |=> (half == 6'd0));

   p_frame_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      32'(fidx) < BLOCK_LEN);

   p_single_pair_r13: assert property (@(posedge clk) disable iff (!rst_n)
      pvld |=> !pvld);

endmodule

bind spdif_bmc_tx spdif_bmc_tx_chk #(.BLOCK_LEN(BLOCK_LEN)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .tick  (enc_tick_i),
   .line  (spdif_o),
   .half  (half_w),
   .fidx  (fidx_w),
   .pvld  (pair_vld_w)
);

// File: tb/tb_spdif_bmc_tx.sv
module tb_spdif_bmc_tx;

   localparam int BLK = 192;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [1:0]     fmt = 2'd0, wsel = 2'd0;
   logic           sclk = 1'b0, lrck = 1'b0, sdat = 1'b0, tick = 1'b0;
   logic [BLK-1:0] cs;
   logic           spdif;

   int checks = 0, errors = 0;
   bit run = 0;
   bit hv [64];
   bit prev_line, started, have_prev, stable_bad;
   int prev_cnt, good_frames;
   logic [31:0] lw_cur;

   always #10 clk = ~clk;

   spdif_bmc_tx #(.BLOCK_LEN(BLK)) dut (
      .clk(clk), .rst_n(rst_n), .fmt_i(fmt), .wsel_i(wsel),
      .sclk_i(sclk), .lrck_i(lrck), .sdata_i(sdat),
      .enc_tick_i(tick), .chstat_i(cs), .spdif_o(spdif)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int wl(input int code);
      return (code == 0) ? 16 : (code == 1) ? 18 : (code == 2) ? 20 : 24;
   endfunction

   function automatic logic [31:0] hi_pat(input int w);
      return 32'h0000B4D2 & ((32'd1 << (w - 8)) - 1);
   endfunction

   function automatic logic [31:0] mk_word(input int n, input int w, input bit right);
      logic [31:0] v;
      v = (hi_pat(w) << 8) | 32'((n + 1) & 255);
      if (right) v = ~v & ((32'd1 << w) - 1);
      return v;
   endfunction

   function automatic string fmt_req(input int f);
      return (f == 0) ? "R2" : (f == 1) ? "R3" : "R4";
   endfunction

   task automatic serial_feed(input int f, input int w);
      int n = 0;
      while (run) begin
         for (int s = 0; s < 64; s++) begin
            int hs, k, ch;
            logic [31:0] word;
            bit b;
            hs = (f == 0) ? (((s + 1) % 64) / 32) : (s / 32);
            k  = s % 32;
            ch = s / 32;
            word = mk_word(n, w, ch == 1);
            if (f == 2) b = (k >= 32 - w) ? word[31 - k] : 1'b0;
            else        b = (k < w) ? word[w - 1 - k] : 1'b0;
            @(negedge clk);
            sclk = 1'b0;
            lrck = (f == 0) ? (hs == 1) : (hs == 0);
            sdat = b;
            @(negedge clk);
            @(negedge clk) sclk = 1'b1;
            @(negedge clk);
         end
         n++;
      end
   endtask

   task automatic process_sub(input int sub, input int f, input int w);
      int frame, fb;
      bit right, par;
      logic [7:0] pat, got, expp;
      logic [31:0] bits, aud, word;
      frame = sub / 2;
      fb    = frame % BLK;
      right = sub[0];
      pat   = right ? 8'b11100100 : ((fb == 0) ? 8'b11101000 : 8'b11100010);
      for (int i = 0; i < 8; i++) got[7 - i] = hv[i];
      expp = pat ^ {8{prev_line}};
      chk(got == expp, "R9 R10", "preamble", got, expp);
      chk(!stable_bad, "R12", "line moved without tick", 1, 0);
      bits = '0;
      for (int t = 4; t < 32; t++) begin
         chk(hv[2*t] != hv[2*t-1], "R8", "slot boundary toggle", t, 1);
         bits[t] = hv[2*t] ^ hv[2*t+1];
      end
      par = 1'b0;
      for (int t = 4; t < 32; t++) par ^= bits[t];
      chk(par == 1'b0, "R7", "even parity", par, 0);
      chk(bits[28] == 1'b0 && bits[29] == 1'b0, "R6", "validity/user", bits[29:28], 0);
      chk(bits[30] == cs[fb], "R11", "channel status", bits[30], cs[fb]);
      aud = 32'(bits[27:4]);
      chk((aud & ((32'd1 << (24 - w)) - 1)) == 0, "R5", "padding slots", aud, 0);
      word = aud >> (24 - w);
      if (!right) begin
         lw_cur = word;
         if (word != 0) begin
            started = 1;
            chk((word >> 8) == hi_pat(w), fmt_req(f), "left word upper bits", word >> 8, hi_pat(w));
            if (have_prev)
               chk(int'(word[7:0]) == ((prev_cnt + 1) & 255), "R13", "pair sequence",
                   word[7:0], (prev_cnt + 1) & 255);
            prev_cnt  = int'(word[7:0]);
            have_prev = 1;
         end else begin
            chk(!started, fmt_req(f), "left word lost after start", word, 1);
         end
      end else if (lw_cur != 0) begin
         chk(word == (~lw_cur & ((32'd1 << w) - 1)), "R13", "right word pairing",
             word, ~lw_cur & ((32'd1 << w) - 1));
         good_frames++;
      end
   endtask

   task automatic decode(input int frames, input int f, input int w);
      int hc = 0, sub = 0;
      while (sub < 2 * frames) begin
         @(negedge clk);
         if (hc > 0 && spdif != hv[hc - 1]) stable_bad = 1;
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
         hv[hc] = spdif;
         if (hc == 63) begin
            process_sub(sub, f, w);
            prev_line  = hv[63];
            stable_bad = 0;
            hc = 0;
            sub++;
         end else hc++;
      end
      run = 0;
   endtask

   task automatic run_cfg(input int f, input int code, input int frames);
      int w;
      w = wl(code);
      fmt = 2'(f); wsel = 2'(code);
      rst_n = 1'b0; tick = 1'b0; sclk = 1'b0; lrck = 1'b0; sdat = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(spdif == 1'b0, "R1", "line after reset", spdif, 0);
      prev_line = 0; started = 0; have_prev = 0; stable_bad = 0;
      good_frames = 0; lw_cur = 0; prev_cnt = 0;
      run = 1;
      fork
         serial_feed(f, w);
         decode(frames, f, w);
      join
      chk(good_frames >= 3, fmt_req(f), "decoded full frames", good_frames, 3);
   endtask

   initial begin
      for (int i = 0; i < BLK; i++) cs[i] = (i % 3 == 0) || (i == BLK - 1);
      run_cfg(0, 3, BLK + 4);
      for (int f = 0; f < 3; f++)
         for (int c = 0; c < 4; c++)
            if (!(f == 0 && c == 3)) run_cfg(f, c, 8);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule